// File: doc/BRIEF.md
# Clocked Serial Master/Slave Transceiver

This block moves bytes over a clock-synchronous serial link. It has one serial clock pin, one data line in each direction and a small register port. Software picks one of two roles. As master, the block derives the transfer clock from the system clock through a power-of-two prescaler and drives the clock pin. As slave, it releases the pin and follows an external clock, which passes through a two-stage synchronizer and an edge detector before any bit moves. Data goes out most significant bit first. The clock idles high, outgoing bits change on its falling edges and incoming bits are sampled on its rising edges.

A master transfer starts when the transmit data register is written while the block is master and idle. In continuous reception the master starts another byte, taken from the current transmit register, straight after each one completes. With the single-stop option set, the master halts after the byte in progress. A slave always keeps receiving, whatever the single-stop option says. An external conflict-error flag drops the block to slave at once and stops any master clocking. A received byte sets a full flag, and reading the byte clears it. A byte that completes while the flag is still set raises an overrun flag.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) both read 0, the clock output enable is low and the clock output is high.
- R2: Control bits 4:2 hold the rate code c. In master mode the serial clock period is 2^(8-c) system clocks, so codes 0 to 6 give 256, 128, 64, 32, 16, 8 and 4.
- R3: Control bit 0 is the role: 1 for master, 0 for slave. The clock output enable equals the role, and while the enable is low the clock output stays high.
- R4: A high conflictErr clears the role bit in the same edge, after which control bit 0 reads 0 and the clock output enable is low. An unstarted or running master transfer is abandoned with no clock edges.
- R5: In master mode with control bit 1 (single-stop) set, the clock stops high after one byte. With bit 1 clear, a new byte built from the current transmit register (address 2) follows at once, until bit 1 is set.
- R6: In slave mode the single-stop bit has no effect: consecutive bytes clocked in from outside are all received.
- R7: Control bits 7:5 read as 0 whatever was written to them.
- R8: Transmit data is shifted out MSB first. It changes after a falling clock edge and is stable at the rising edge.
- R9: When 8 bits have been sampled, the byte appears at address 3 and status bit 0 (full) is set. A read of address 3 clears the full flag.
- R10: A byte that completes while the full flag is set raises status bit 1 (overrun) and replaces the byte at address 3. Any write to address 1 clears the overrun flag.
- R11: In slave mode the bits on sdi are sampled at rising edges of sclkIn as seen through the synchronizer, and the byte is received MSB first.
- R12: Reserved rate code 7 is treated as code 6, giving a period of 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (a read of address 3 clears the full flag) |
| addr | input | 2 | Register address: 0 control, 1 status, 2 transmit, 3 receive |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| conflictErr | input | 1 | Conflict error flag, forces slave role |
| sclkIn | input | 1 | External serial clock (slave mode) |
| sclkOut | output | 1 | Generated serial clock (master mode), idles high |
| sclkOe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The assertions check on every cycle that a conflict drops the clock enable, that the clock output is high while it is not driven, and that master half periods never go below two cycles. They also check that a completed byte sets the full flag, that a receive read clears it, and that overrun only rises while the flag is already set. The bench scenarios cover what no single-cycle property can show. These are the exact clock periods for each rate code, including the reserved one, the bit order and contents on both data lines, and stopping after one byte against continuing with a changed transmit byte. They also cover reception in slave mode with single-stop set, and overrun followed by its clearing write.

// File: rtl/ssx_pkg.sv
`timescale 1ns/1ps
package ssx_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_TX   = 2'd2;
  localparam logic [1:0] ADDR_RX   = 2'd3;

  // strobes from the control to the datapath, one cycle wide
  typedef struct packed {
    logic loadTx;    // first falling edge of a byte: load shifter
    logic shiftOut;  // later falling edge: advance transmit shifter
    logic shiftIn;   // rising edge: sample sdi
    logic byteDone;  // rising edge that completes a byte
  } ssxStrobe_t;
endpackage

// File: rtl/ssx_ctrl.sv
`timescale 1ns/1ps
module ssx_ctrl
  import ssx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int RATE_W       = 3,
  parameter int MAX_DIV_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [RATE_W+1:0] ctrlWrData,
  input  logic              conflictErr,
  input  logic              sclkIn,
  output logic              roleQ,
  output logic              stopQ,
  output logic [RATE_W-1:0] rateQ,
  output logic              busy,
  output logic              sclkOut,
  output logic              sclkOe,
  output ssxStrobe_t        stb
);
  localparam int CNT_W    = $clog2(DATA_W);
  localparam int HALF_W   = MAX_DIV_LOG2 - 1;
  localparam int MAX_CODE = MAX_DIV_LOG2 - 2;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              roleD;
  logic              ctrlWr;
  logic              startReq;
  logic              mRun;
  logic              mClk;
  logic [HALF_W-1:0] halfCnt;
  logic [HALF_W-1:0] halfLim;
  logic [RATE_W-1:0] codeEff;
  logic              halfEnd;
  logic              mFall;
  logic              mRise;
  logic [2:0]        syncQ;
  logic              sFall;
  logic              sRise;
  logic              fallE;
  logic              riseE;
  logic [CNT_W-1:0]  bitCnt;

  assign ctrlWr = wrEn && (addr == ADDR_CTRL);

  // next role: a conflict always wins over a software write
  always_comb begin
    roleD = roleQ;
    if (ctrlWr) roleD = ctrlWrData[0];
    if (conflictErr) roleD = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      roleQ <= 1'b0;
      stopQ <= 1'b0;
      rateQ <= '0;
    end else begin
      roleQ <= roleD;
      if (ctrlWr) begin
        stopQ <= ctrlWrData[1];
        rateQ <= ctrlWrData[RATE_W+1:2];
      end
    end
  end

  // rate code to half-period limit; the reserved code is clamped
  assign codeEff = (rateQ > RATE_W'(MAX_CODE)) ? RATE_W'(MAX_CODE) : rateQ;

  always_comb begin
    halfLim = '0;
    for (int k = 0; k <= MAX_CODE; k++) begin
      if (codeEff == RATE_W'(k)) halfLim = HALF_W'((1 << (HALF_W - k)) - 1);
    end
  end

  assign startReq = wrEn && (addr == ADDR_TX) && roleQ && !mRun;
  assign halfEnd  = mRun && (halfCnt == halfLim);
  assign mFall    = halfEnd && mClk;
  assign mRise    = halfEnd && !mClk;

  // master clock generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun    <= 1'b0;
      mClk    <= 1'b1;
      halfCnt <= '0;
    end else if (!roleD) begin
      mRun    <= 1'b0;
      mClk    <= 1'b1;
      halfCnt <= '0;
    end else if (!mRun) begin
      mClk    <= 1'b1;
      halfCnt <= '0;
      if (startReq) mRun <= 1'b1;
    end else if (halfEnd) begin
      halfCnt <= '0;
      mClk    <= ~mClk;
      if (mRise && (bitCnt == LAST_BIT) && stopQ) mRun <= 1'b0;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  // slave clock synchronizer and edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 3'b111;
    else       syncQ <= {syncQ[1:0], sclkIn};
  end

  assign sRise = syncQ[1] && !syncQ[2];
  assign sFall = !syncQ[1] && syncQ[2];

  assign fallE = !conflictErr && (roleQ ? mFall : sFall);
  assign riseE = !conflictErr && (roleQ ? mRise : sRise);

  // bit position within the byte, restarted on any role change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (roleD != roleQ) begin
      bitCnt <= '0;
    end else if (riseE) begin
      bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    stb.loadTx   = fallE && (bitCnt == '0);
    stb.shiftOut = fallE && (bitCnt != '0);
    stb.shiftIn  = riseE;
    stb.byteDone = riseE && (bitCnt == LAST_BIT);
  end

  assign busy    = roleQ ? mRun : (bitCnt != '0);
  assign sclkOut = mClk;
  assign sclkOe  = roleQ;
endmodule

// File: rtl/ssx_dpath.sv
`timescale 1ns/1ps
module ssx_dpath
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdi,
  input  ssxStrobe_t        stb,
  output logic              sdo,
  output logic [DATA_W-1:0] txDataQ,
  output logic [DATA_W-1:0] rxDataQ,
  output logic              rxFull,
  output logic              overrun
);
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-2:0] rxShift;
  logic              rxRead;
  logic              statWr;

  assign rxRead = rdEn && (addr == ADDR_RX);
  assign statWr = wrEn && (addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txDataQ <= '0;
    else if (wrEn && (addr == ADDR_TX)) txDataQ <= wrData;
  end

  // transmit shifter, MSB leaves first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShift <= '1;
    else if (stb.loadTx)   txShift <= txDataQ;
    else if (stb.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  assign sdo = txShift[DATA_W-1];

  // receive shifter holds the first seven bits of a byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxShift <= '0;
    else if (stb.shiftIn) rxShift <= {rxShift[DATA_W-3:0], sdi};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDataQ <= '0;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (stb.byteDone) begin
        rxDataQ <= {rxShift, sdi};
        rxFull  <= 1'b1;
      end else if (rxRead) begin
        rxFull  <= 1'b0;
      end
      if (stb.byteDone && rxFull && !rxRead) overrun <= 1'b1;
      else if (statWr)                       overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_serial_xcvr.sv
`timescale 1ns/1ps
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int RATE_W       = 3,
  parameter int MAX_DIV_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              conflictErr,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe,
  input  logic              sdi,
  output logic              sdo
);
  ssxStrobe_t        stb;
  logic              roleQ;
  logic              stopQ;
  logic [RATE_W-1:0] rateQ;
  logic              busy;
  logic [DATA_W-1:0] txDataQ;
  logic [DATA_W-1:0] rxDataQ;
  logic              rxFull;
  logic              overrun;

  ssx_ctrl #(
    .DATA_W(DATA_W), .RATE_W(RATE_W), .MAX_DIV_LOG2(MAX_DIV_LOG2)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .ctrlWrData(wrData[RATE_W+1:0]), .conflictErr(conflictErr),
    .sclkIn(sclkIn), .roleQ(roleQ), .stopQ(stopQ), .rateQ(rateQ),
    .busy(busy), .sclkOut(sclkOut), .sclkOe(sclkOe), .stb(stb)
  );

  ssx_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .sdi(sdi), .stb(stb), .sdo(sdo),
    .txDataQ(txDataQ), .rxDataQ(rxDataQ), .rxFull(rxFull), .overrun(overrun)
  );

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdData = DATA_W'({rateQ, stopQ, roleQ});
      ADDR_STAT: rdData = DATA_W'({busy, overrun, rxFull});
      ADDR_TX:   rdData = txDataQ;
      default:   rdData = rxDataQ;
    endcase
  end
endmodule

// File: rtl/ssx_checker.sv
`timescale 1ns/1ps
module ssx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       conflictErr,
  input logic       sclkOut,
  input logic       sclkOe,
  input logic       rdEn,
  input logic [1:0] addr,
  input logic       rxFull,
  input logic       overrun,
  input logic       byteDone
);
  p_conflict_demote_r4: assert property (@(posedge clk) disable iff (!rstN)
    conflictErr |=> !sclkOe);

  p_idle_clock_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    !sclkOe |-> sclkOut);

  p_min_half_period_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOe && $past(sclkOe) && !$stable(sclkOut)) |=> $stable(sclkOut));

  p_done_sets_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> rxFull);

  p_read_clears_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd3 && !byteDone) |=> !rxFull);

  p_overrun_needs_full_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxFull));
endmodule

bind sync_serial_xcvr ssx_checker chk_i (
  .clk(clk), .rstN(rstN), .conflictErr(conflictErr), .sclkOut(sclkOut),
  .sclkOe(sclkOe), .rdEn(rdEn), .addr(addr), .rxFull(rxFull),
  .overrun(overrun), .byteDone(stb.byteDone)
);

// File: tb/sync_serial_xcvr_tb_top.sv
`timescale 1ns/1ps
module sync_serial_xcvr_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       conflictErr = 1'b0;
  logic       sclkInDrv = 1'b1;
  logic       sclkOut;
  logic       sclkOe;
  logic       sdi = 1'b1;
  logic       sdo;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] expTxQ[$];
  logic [7:0] sdiNext = 8'hFF;
  logic [7:0] curSdi = 8'hFF;
  int fallIdx = 0;
  logic [7:0] capByte = 8'h00;
  int capCnt = 0;
  int capTotal = 0;

  sync_serial_xcvr dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .conflictErr(conflictErr),
    .sclkIn(sclkInDrv), .sclkOut(sclkOut), .sclkOe(sclkOe),
    .sdi(sdi), .sdo(sdo)
  );

  always #10 clk = ~clk;

  wire capClk = sclkOut & sclkInDrv;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // bench-side partner: drives sdi after falling edges, MSB first
  always @(negedge capClk) begin
    if (rstN) begin
      if (fallIdx == 0) curSdi = sdiNext;
      sdi = curSdi[7 - fallIdx];
      fallIdx = (fallIdx + 1) % 8;
    end
  end

  // monitor: captures sdo at rising edges and scores against the queue (R8)
  always @(posedge capClk) begin
    if (rstN) begin
      capByte = {capByte[6:0], sdo};
      capCnt++;
      if (capCnt == 8) begin
        capCnt = 0;
        capTotal++;
        if (expTxQ.size() == 0) begin
          check(1'b0, "R8 unexpected byte on sdo", capByte, 0);
        end else begin
          logic [7:0] e;
          e = expTxQ.pop_front();
          check(capByte == e, "R8 sdo byte", capByte, e);
        end
      end
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic sendTx(input logic [7:0] tx);
    expTxQ.push_back(tx);
    regWrite(2'd2, tx);
  endtask

  task automatic waitFull(input string tag);
    logic [7:0] s;
    int n;
    n = 0;
    s = 8'h00;
    while (n < 5000 && s[0] !== 1'b1) begin
      regRead(2'd1, s);
      n++;
    end
    check(s[0] === 1'b1, tag, s, 1);
  endtask

  task automatic measurePeriod(output int per);
    int n;
    n = 0;
    @(negedge clk);
    while (sclkOut !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (sclkOut !== 1'b1 && n < 2000);
    do begin @(negedge clk); n++; end while (sclkOut !== 1'b0 && n < 2000);
    per = n;
  endtask

  task automatic masterByte(input logic [7:0] ctrl, input logic [7:0] tx,
                            input logic [7:0] rx, input int expPer, input string tag);
    int per;
    logic [7:0] d;
    regWrite(2'd0, ctrl);
    sdiNext = rx;
    sendTx(tx);
    measurePeriod(per);
    check(per == expPer, tag, per, expPer);
    waitFull("R9 full flag after master byte");
    regRead(2'd3, d);
    check(d == rx, "R8 R9 master received byte", d, rx);
    regRead(2'd1, d);
    check(d[0] == 1'b0, "R9 full cleared by read", d[0], 0);
  endtask

  task automatic slaveByte(input logic [7:0] rx);
    sdiNext = rx;
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); sclkInDrv = 1'b0;
      repeat (16) @(negedge clk);
      sclkInDrv = 1'b1;
      repeat (16) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    int edgesSeen;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(2'd0, d);
    check(d == 8'h00, "R1 control after reset", d, 0);
    regRead(2'd1, d);
    check(d == 8'h00, "R1 status after reset", d, 0);
    check(sclkOe == 1'b0, "R1 clock enable after reset", sclkOe, 0);
    check(sclkOut == 1'b1, "R1 clock level after reset", sclkOut, 1);

    // R7 unused bits
    regWrite(2'd0, 8'hE0);
    regRead(2'd0, d);
    check(d == 8'h00, "R7 unused control bits", d, 0);

    // R2 R3 R5 master single byte at divide-by-4
    regWrite(2'd0, 8'h1B);
    check(sclkOe == 1'b1, "R3 master drives clock", sclkOe, 1);
    masterByte(8'h1B, 8'hA5, 8'h3C, 4, "R2 period code 6");
    edgesSeen = capTotal;
    repeat (60) @(negedge clk);
    check(sclkOut == 1'b1, "R5 clock idle high after single byte", sclkOut, 1);
    check(capTotal == edgesSeen && capCnt == 0, "R5 no further byte", capCnt, 0);

    // R2 code 4, divide-by-16
    masterByte(8'h13, 8'h81, 8'h7E, 16, "R2 period code 4");
    // R12 reserved code 7 acts as code 6
    masterByte(8'h1F, 8'h00, 8'hFF, 4, "R12 period reserved code");

    // R5 continuous master reception at divide-by-256
    regWrite(2'd0, 8'h01);
    sdiNext = 8'h55;
    sendTx(8'h12);
    waitFull("R5 first continuous byte");
    regRead(2'd3, d);
    check(d == 8'h55, "R5 first continuous rx", d, 8'h55);
    sdiNext = 8'h99;
    sendTx(8'h34);
    regWrite(2'd0, 8'h03);
    waitFull("R5 second continuous byte");
    regRead(2'd3, d);
    check(d == 8'h99, "R5 second continuous rx", d, 8'h99);
    repeat (700) @(negedge clk);
    regRead(2'd1, d);
    check(d == 8'h00, "R5 stopped after single-stop set", d, 0);
    check(expTxQ.size() == 0, "R5 R8 all master bytes seen", expTxQ.size(), 0);

    // R4 conflict demotes before any clock edge
    regWrite(2'd0, 8'h01);
    regWrite(2'd2, 8'h77);
    repeat (20) @(negedge clk);
    conflictErr = 1'b1;
    @(negedge clk);
    conflictErr = 1'b0;
    check(sclkOe == 1'b0, "R4 clock enable dropped", sclkOe, 0);
    check(sclkOut == 1'b1, "R4 clock released high", sclkOut, 1);
    regRead(2'd0, d);
    check(d[0] == 1'b0, "R4 role bit cleared", d[0], 0);
    repeat (300) @(negedge clk);
    check(capCnt == 0 && fallIdx == 0, "R4 no edges after conflict", capCnt, 0);

    // R6 R11 slave with single-stop set keeps receiving
    regWrite(2'd0, 8'h02);
    sendTx(8'hC3);
    slaveByte(8'hB4);
    regRead(2'd1, d);
    check(d[0] == 1'b1, "R11 slave full flag", d[0], 1);
    regRead(2'd3, d);
    check(d == 8'hB4, "R11 slave received byte", d, 8'hB4);
    sendTx(8'h5A);
    slaveByte(8'h0F);
    regRead(2'd3, d);
    check(d == 8'h0F, "R6 second slave byte despite single-stop", d, 8'h0F);

    // R10 overrun
    expTxQ.push_back(8'h5A);
    slaveByte(8'h11);
    expTxQ.push_back(8'h5A);
    slaveByte(8'h22);
    regRead(2'd1, d);
    check(d[1:0] == 2'b11, "R10 overrun and full set", d[1:0], 3);
    regRead(2'd3, d);
    check(d == 8'h22, "R10 newest byte kept", d, 8'h22);
    regWrite(2'd1, 8'h00);
    regRead(2'd1, d);
    check(d[1] == 1'b0, "R10 overrun cleared by status write", d[1], 0);
    check(expTxQ.size() == 0, "R8 all slave bytes seen", expTxQ.size(), 0);

    finishRun();
  end
endmodule